// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block holds one load-linked reservation for each hardware thread and rules on every store-conditional in the same cycle it is presented. A load-linked request records the thread's reservation. The recorded address is the access address with its low `GRAN_BITS` bits cleared, so the reservation covers one aligned granule (16 bytes by default). A store-conditional request carries a thread number, an address and an uncacheable attribute. The monitor answers at once with three things: whether the store may be sent to memory, the result code for the destination register, and the reason for a failure.

A snoop port reports writes to a line made by other agents. Every reservation that holds the written granule is dropped. Each thread also keeps a saturating count of consecutive failed store-conditionals. A one-cycle warning pulse, tagged with the thread number, fires each time that count reaches a multiple of `WARN_PERIOD` (100000 by default). Software or debug logic can use the pulse to spot livelock.

Top module: `llsc_monitor`

## Requirements
- R1: A load-linked request records its address with the low `GRAN_BITS` bits cleared and sets the thread's reservation flag. The low address bits of a later store-conditional are ignored in the comparison.
- R2: A cacheable store-conditional whose thread has its flag set and whose granule equals the recorded granule gets `sc_issue`=1, `sc_result`=1 and `sc_cause`=0, in the same cycle.
- R3: A failing cacheable store-conditional gets `sc_issue`=0 and `sc_result`=0. Its `sc_cause` is 1 when the flag is clear (checked first) and 2 when the granule differs.
- R4: Every cacheable store-conditional, whether it passes or fails, clears its thread's reservation flag.
- R5: An uncacheable store-conditional gets `sc_issue`=1, `sc_result`=2 and `sc_cause`=0. It changes neither the reservation nor the failure count.
- R6: Each failed cacheable store-conditional increments its thread's failure count. In the cycle after the failure that brings the count to a multiple of `WARN_PERIOD`, `livelock_warn` is 1 for exactly one cycle and `warn_tid` names the thread.
- R7: A successful cacheable store-conditional resets its thread's failure count to zero.
- R8: A snoop whose granule equals a held reservation clears that flag for every thread holding it. When the snoop arrives in the same cycle as a store-conditional to that granule, the snoop wins and the store-conditional fails with cause 1.
- R9: When a load-linked request and a store-conditional or a snoop affect the same thread in the same cycle, the store-conditional is judged on the old state and the load-linked reservation is the one that remains afterwards.
- R10: After a synchronous active-low reset, all flags are clear, all failure counts are zero and `livelock_warn` is 0.
- R11: The failure count saturates at 2^`CNT_W`-1. Once saturated, further failures raise no more warnings.
- R12: Reservations of different threads are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ll_valid | input | 1 | Load-linked request |
| ll_tid | input | TID_W | Thread of the load-linked request |
| ll_addr | input | ADDR_W | Physical address of the load-linked request |
| sc_valid | input | 1 | Store-conditional request |
| sc_tid | input | TID_W | Thread of the store-conditional |
| sc_addr | input | ADDR_W | Physical address of the store-conditional |
| sc_uncached | input | 1 | Store-conditional is uncacheable |
| snp_valid | input | 1 | Write by another agent observed |
| snp_addr | input | ADDR_W | Address of the snooped write |
| sc_issue | output | 1 | Send the store-conditional to memory |
| sc_result | output | 2 | Result code: 0 fail, 1 success, 2 uncacheable |
| sc_cause | output | 2 | Failure reason: 0 none, 1 flag clear, 2 granule mismatch |
| livelock_warn | output | 1 | One-cycle livelock warning pulse |
| warn_tid | output | TID_W | Thread the warning refers to |

## Verification
Three pairs of functions can meet in one cycle. A snoop can land on the granule a store-conditional is checking. A load-linked request can arrive on the same thread as a store-conditional, and a load-linked request can arrive on the same thread as a snoop. The bench provokes each pairing with directed cycles. It then keeps them frequent in random traffic by drawing every address from three granules and enabling each port independently. Each pairing is judged by the verdict in that cycle, and by the outcome of a later store-conditional, which shows which reservation survived.

// File: rtl/llsc_pkg.sv
// Shared encodings for the load-linked reservation monitor.
package llsc_pkg;

    // Result code written to the destination register of a store-conditional.
    typedef enum logic [1:0] {
        RES_FAIL     = 2'd0,
        RES_PASS     = 2'd1,
        RES_UNCACHED = 2'd2
    } sc_result_e;

    // Reason a cacheable store-conditional failed.
    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'd0,
        CAUSE_NOFLAG   = 2'd1,
        CAUSE_MISMATCH = 2'd2
    } sc_cause_e;

endpackage

// File: rtl/llsc_resv_slot.sv
// One thread's reservation: a valid flag plus the reserved granule address.
// Assumes set_gran_i already has its low granule bits cleared by the caller.
// A set request has priority over a clear request in the same cycle.
module llsc_resv_slot #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_i,
    input  logic [ADDR_W-1:0] set_gran_i,
    input  logic              clr_i,
    output logic              valid_o,
    output logic [ADDR_W-1:0] gran_o
);

    // Reservation state update: reset, then set, then clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            gran_o  <= '0;
        end else if (set_i) begin
            valid_o <= 1'b1;
            gran_o  <= set_gran_i;
        end else if (clr_i) begin
            valid_o <= 1'b0;
        end
    end

endmodule

// File: rtl/llsc_fail_counter.sv
// Saturating count of consecutive store-conditional failures for one thread.
// A phase counter tracks the position within WARN_PERIOD, so no divider is
// needed. warn_o pulses for one cycle after the failure that makes the count
// a multiple of WARN_PERIOD. Assumes fail_i and pass_i are never both high.
module llsc_fail_counter #(
    parameter int CNT_W       = 32,
    parameter int WARN_PERIOD = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fail_i,
    input  logic pass_i,
    output logic warn_o
);

    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam int               PH_W     = (WARN_PERIOD > 1) ? $clog2(WARN_PERIOD) : 1;
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(WARN_PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [PH_W-1:0]  phase_q;

    // Count update, phase tracking and warning pulse generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= '0;
            warn_o  <= 1'b0;
        end else begin
            warn_o <= 1'b0;
            if (pass_i) begin
                cnt_q   <= '0;
                phase_q <= '0;
            end else if (fail_i && (cnt_q != CNT_MAX)) begin
                cnt_q <= cnt_q + 1'b1;
                if (phase_q == PH_LAST) begin
                    phase_q <= '0;
                    warn_o  <= 1'b1;
                end else begin
                    phase_q <= phase_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/llsc_verdict.sv
// Combinational store-conditional decision for the selected thread.
// Assumes snp_hit_i already says that a same-cycle snoop hits this
// thread's held reservation.
module llsc_verdict
    import llsc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              sc_valid_i,
    input  logic              sc_uncached_i,
    input  logic [ADDR_W-1:0] sc_gran_i,
    input  logic              resv_valid_i,
    input  logic [ADDR_W-1:0] resv_gran_i,
    input  logic              snp_hit_i,
    output logic              issue_o,
    output sc_result_e        result_o,
    output sc_cause_e         cause_o,
    output logic              fail_o,
    output logic              pass_o
);

    // Order of checks: uncached bypass, flag (with snoop), then granule match.
    always_comb begin
        issue_o  = 1'b0;
        result_o = RES_FAIL;
        cause_o  = CAUSE_NONE;
        fail_o   = 1'b0;
        pass_o   = 1'b0;
        if (sc_valid_i) begin
            if (sc_uncached_i) begin
                issue_o  = 1'b1;
                result_o = RES_UNCACHED;
            end else if (!resv_valid_i || snp_hit_i) begin
                cause_o = CAUSE_NOFLAG;
                fail_o  = 1'b1;
            end else if (resv_gran_i != sc_gran_i) begin
                cause_o = CAUSE_MISMATCH;
                fail_o  = 1'b1;
            end else begin
                issue_o  = 1'b1;
                result_o = RES_PASS;
                pass_o   = 1'b1;
            end
        end
    end

endmodule

// File: rtl/llsc_monitor.sv
// Load-linked reservation monitor, top level.
// Keeps one reservation and one failure counter per hardware thread. It gives
// a same-cycle verdict on one store-conditional per cycle, drops reservations
// hit by snooped writes, and pulses a livelock warning. Assumes at most one
// load-linked and one store-conditional request per cycle.
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int ADDR_W      = 32,
    parameter int GRAN_BITS   = 4,
    parameter int CNT_W       = 32,
    parameter int WARN_PERIOD = 100000,
    localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ll_valid,
    input  logic [TID_W-1:0]  ll_tid,
    input  logic [ADDR_W-1:0] ll_addr,
    input  logic              sc_valid,
    input  logic [TID_W-1:0]  sc_tid,
    input  logic [ADDR_W-1:0] sc_addr,
    input  logic              sc_uncached,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              sc_issue,
    output logic [1:0]        sc_result,
    output logic [1:0]        sc_cause,
    output logic              livelock_warn,
    output logic [TID_W-1:0]  warn_tid
);

    localparam logic [ADDR_W-1:0] GRAN_MASK = ~((ADDR_W'(1) << GRAN_BITS) - ADDR_W'(1));

    logic [ADDR_W-1:0] ll_gran, sc_gran, snp_gran;
    logic              resv_valid [NUM_THREADS];
    logic [ADDR_W-1:0] resv_gran  [NUM_THREADS];
    logic [NUM_THREADS-1:0] snp_hit, warn_vec;
    logic              sel_valid, sel_hit;
    logic [ADDR_W-1:0] sel_gran;
    logic              v_fail, v_pass;
    sc_result_e        v_result;
    sc_cause_e         v_cause;

    assign ll_gran  = ll_addr  & GRAN_MASK;
    assign sc_gran  = sc_addr  & GRAN_MASK;
    assign snp_gran = snp_addr & GRAN_MASK;

    // Per-thread reservation slot, snoop hit detection and failure counter.
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        logic ll_here, sc_here;
        assign ll_here    = ll_valid && (ll_tid == TID_W'(t));
        assign sc_here    = sc_valid && !sc_uncached && (sc_tid == TID_W'(t));
        assign snp_hit[t] = snp_valid && resv_valid[t] && (resv_gran[t] == snp_gran);

        llsc_resv_slot #(.ADDR_W(ADDR_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .set_i      (ll_here),
            .set_gran_i (ll_gran),
            .clr_i      (sc_here || snp_hit[t]),
            .valid_o    (resv_valid[t]),
            .gran_o     (resv_gran[t])
        );

        llsc_fail_counter #(.CNT_W(CNT_W), .WARN_PERIOD(WARN_PERIOD)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .fail_i (sc_here && v_fail),
            .pass_i (sc_here && v_pass),
            .warn_o (warn_vec[t])
        );
    end

    // Select the reservation state of the store-conditional's thread.
    always_comb begin
        sel_valid = 1'b0;
        sel_gran  = '0;
        sel_hit   = 1'b0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            if (sc_tid == TID_W'(t)) begin
                sel_valid = resv_valid[t];
                sel_gran  = resv_gran[t];
                sel_hit   = snp_hit[t];
            end
        end
    end

    llsc_verdict #(.ADDR_W(ADDR_W)) u_verdict (
        .sc_valid_i    (sc_valid),
        .sc_uncached_i (sc_uncached),
        .sc_gran_i     (sc_gran),
        .resv_valid_i  (sel_valid),
        .resv_gran_i   (sel_gran),
        .snp_hit_i     (sel_hit),
        .issue_o       (sc_issue),
        .result_o      (v_result),
        .cause_o       (v_cause),
        .fail_o        (v_fail),
        .pass_o        (v_pass)
    );

    assign sc_result     = v_result;
    assign sc_cause      = v_cause;
    assign livelock_warn = |warn_vec;

    // Encode which thread raised the warning (at most one per cycle).
    always_comb begin
        warn_tid = '0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            if (warn_vec[t]) warn_tid = TID_W'(t);
        end
    end

endmodule

// File: rtl/llsc_monitor_checker.sv
// Port-level properties of the reservation monitor, bound to every instance.
// Assumes the same parameters as the bound instance.
module llsc_monitor_checker #(
    parameter int ADDR_W    = 32,
    parameter int GRAN_BITS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sc_valid,
    input logic [ADDR_W-1:0] sc_addr,
    input logic              sc_uncached,
    input logic              snp_valid,
    input logic [ADDR_W-1:0] snp_addr,
    input logic              sc_issue,
    input logic [1:0]        sc_result,
    input logic [1:0]        sc_cause,
    input logic              livelock_warn
);

    localparam int SHIFT = GRAN_BITS;

    // Uncacheable requests always go out with code 2.
    p_uncached_issue_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_valid && sc_uncached) |-> (sc_issue && sc_result == 2'd2 && sc_cause == 2'd0));

    // A failure result never issues and always carries a cause.
    p_fail_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_valid && !sc_uncached && sc_result == 2'd0) |-> (!sc_issue && sc_cause != 2'd0));

    // A success result issues with no cause.
    p_pass_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_valid && sc_result == 2'd1) |-> (sc_issue && sc_cause == 2'd0));

    // Snoop to the same granule in the same cycle forces a failure.
    p_snoop_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_valid && !sc_uncached && snp_valid && ((sc_addr >> SHIFT) == (snp_addr >> SHIFT)))
        |-> (!sc_issue && sc_result == 2'd0));

    // A warning pulse follows a failed cacheable store-conditional.
    p_warn_after_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
        livelock_warn |-> $past(sc_valid && !sc_uncached && sc_result == 2'd0));

    // With no request, nothing is issued and no cause is shown.
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sc_valid |-> (!sc_issue && sc_cause == 2'd0));

endmodule

bind llsc_monitor llsc_monitor_checker #(.ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sc_valid      (sc_valid),
    .sc_addr       (sc_addr),
    .sc_uncached   (sc_uncached),
    .snp_valid     (snp_valid),
    .snp_addr      (snp_addr),
    .sc_issue      (sc_issue),
    .sc_result     (sc_result),
    .sc_cause      (sc_cause),
    .livelock_warn (livelock_warn)
);

// File: tb/llsc_monitor_bench.sv
// Self-checking bench: directed corner cases, then seeded random traffic,
// all compared against a behavioural model kept inside the bench.
module llsc_monitor_bench;

    localparam int NT    = 2;
    localparam int AW    = 16;
    localparam int GB    = 4;
    localparam int CW    = 4;
    localparam int WP    = 5;
    localparam int TW    = 1;
    localparam int CMAX  = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ll_valid = 1'b0;
    logic [TW-1:0] ll_tid = '0;
    logic [AW-1:0] ll_addr = '0;
    logic          sc_valid = 1'b0;
    logic [TW-1:0] sc_tid = '0;
    logic [AW-1:0] sc_addr = '0;
    logic          sc_uncached = 1'b0;
    logic          snp_valid = 1'b0;
    logic [AW-1:0] snp_addr = '0;
    logic          sc_issue;
    logic [1:0]    sc_result, sc_cause;
    logic          livelock_warn;
    logic [TW-1:0] warn_tid;

    int checks = 0;
    int errors = 0;
    int warn_seen = 0;

    // Behavioural model state.
    logic          m_flag [NT];
    logic [AW-1:0] m_gran [NT];
    int            m_cnt  [NT];
    logic          m_warn;
    int            m_wtid;

    llsc_monitor #(.NUM_THREADS(NT), .ADDR_W(AW), .GRAN_BITS(GB),
                   .CNT_W(CW), .WARN_PERIOD(WP)) u_llsc_monitor (
        .clk(clk), .rst_n(rst_n), .ll_valid(ll_valid), .ll_tid(ll_tid), .ll_addr(ll_addr),
        .sc_valid(sc_valid), .sc_tid(sc_tid), .sc_addr(sc_addr), .sc_uncached(sc_uncached),
        .snp_valid(snp_valid), .snp_addr(snp_addr), .sc_issue(sc_issue), .sc_result(sc_result),
        .sc_cause(sc_cause), .livelock_warn(livelock_warn), .warn_tid(warn_tid)
    );

    always #10 clk = ~clk;

    function automatic logic [AW-1:0] gran(input logic [AW-1:0] a);
        return a & ~AW'((1 << GB) - 1);
    endfunction

    // Expected cause code: 0 none, 1 flag clear, 2 mismatch.
    function automatic int exp_cause();
        int t = int'(sc_tid);
        if (!sc_valid || sc_uncached) return 0;
        if (!m_flag[t] || (snp_valid && gran(snp_addr) == m_gran[t])) return 1;
        if (gran(sc_addr) != m_gran[t]) return 2;
        return 0;
    endfunction

    function automatic int exp_result();
        if (!sc_valid) return 0;
        if (sc_uncached) return 2;
        return (exp_cause() == 0) ? 1 : 0;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int t = 0; t < NT; t++) begin
            m_flag[t] = 1'b0; m_gran[t] = '0; m_cnt[t] = 0;
        end
        m_warn = 1'b0; m_wtid = 0;
    endtask

    // Advance the model with the inputs present at the clock edge.
    task automatic model_step();
        int st = int'(sc_tid);
        int c  = exp_cause();
        m_warn = 1'b0;
        if (sc_valid && !sc_uncached) begin
            if (c != 0) begin
                if (m_cnt[st] < CMAX) begin
                    m_cnt[st]++;
                    if (m_cnt[st] % WP == 0) begin m_warn = 1'b1; m_wtid = st; end
                end
            end else begin
                m_cnt[st] = 0;
            end
        end
        for (int t = 0; t < NT; t++) begin
            if (ll_valid && int'(ll_tid) == t) begin
                m_flag[t] = 1'b1; m_gran[t] = gran(ll_addr);
            end else if (sc_valid && !sc_uncached && st == t) begin
                m_flag[t] = 1'b0;
            end else if (snp_valid && m_flag[t] && m_gran[t] == gran(snp_addr)) begin
                m_flag[t] = 1'b0;
            end
        end
    endtask

    // One cycle: inputs are set after a falling edge; check verdict, clock, check warning.
    task automatic run_cycle(input string tag);
        #2;
        if (sc_valid) begin
            check(tag, "sc_result", int'(sc_result), exp_result());
            check(tag, "sc_cause",  int'(sc_cause),  exp_cause());
            check(tag, "sc_issue",  int'(sc_issue),  (exp_result() != 0) ? 1 : 0);
        end
        @(posedge clk);
        model_step();
        @(negedge clk);
        check({tag, " R6"}, "livelock_warn", int'(livelock_warn), int'(m_warn));
        if (livelock_warn) warn_seen++;
        if (m_warn) check({tag, " R6"}, "warn_tid", int'(warn_tid), m_wtid);
    endtask

    task automatic drive(input logic llv, input int llt, input logic [AW-1:0] lla,
                         input logic scv, input int sct, input logic [AW-1:0] sca, input logic unc,
                         input logic snv, input logic [AW-1:0] sna, input string tag);
        ll_valid = llv; ll_tid = TW'(llt); ll_addr = lla;
        sc_valid = scv; sc_tid = TW'(sct); sc_addr = sca; sc_uncached = unc;
        snp_valid = snv; snp_addr = sna;
        run_cycle(tag);
    endtask

    task automatic ll(input int t, input logic [AW-1:0] a, input string tag);
        drive(1, t, a, 0, 0, '0, 0, 0, '0, tag);
    endtask

    task automatic sc(input int t, input logic [AW-1:0] a, input logic unc, input string tag);
        drive(0, 0, '0, 1, t, a, unc, 0, '0, tag);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int w0;
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: quiet after reset, and no reservation held by any thread.
        check("R10", "livelock_warn", int'(livelock_warn), 0);
        check("R10", "sc_issue idle", int'(sc_issue), 0);
        sc(0, 16'h0100, 0, "R10 t0");
        sc(1, 16'h0100, 0, "R10 t1");

        // R1/R2/R4: low bits ignored, pass, then reservation consumed.
        ll(0, 16'h0105, "R1");
        sc(0, 16'h010A, 0, "R2 pass");
        sc(0, 16'h010A, 0, "R4 consumed");
        // R3: granule mismatch gives cause 2.
        ll(0, 16'h0105, "R1");
        sc(0, 16'h0115, 0, "R3 mismatch");
        // R8: snoop and SC to the same granule in one cycle.
        ll(0, 16'h0105, "R1");
        drive(0, 0, '0, 1, 0, 16'h010A, 0, 1, 16'h010F, "R8 same cycle");
        // R8: snoop alone clears both threads holding the granule.
        ll(0, 16'h0200, "R1"); ll(1, 16'h0208, "R1");
        drive(0, 0, '0, 0, 0, '0, 0, 1, 16'h020C, "R8 snoop");
        sc(0, 16'h0200, 0, "R8 t0 cleared");
        sc(1, 16'h0200, 0, "R8 t1 cleared");
        // R9: LL and SC on one thread in one cycle; LL survives.
        drive(1, 0, 16'h0300, 1, 0, 16'h0300, 0, 0, '0, "R9 ll+sc");
        sc(0, 16'h0303, 0, "R9 ll kept");
        // R9: LL and snoop on one thread in one cycle; LL survives.
        ll(0, 16'h0300, "R1");
        drive(1, 0, 16'h0300, 0, 0, '0, 0, 1, 16'h0300, "R9 ll+snoop");
        sc(0, 16'h0300, 0, "R9 ll kept snoop");
        // R12: independent threads.
        ll(0, 16'h0300, "R12"); ll(1, 16'h0400, "R12");
        sc(1, 16'h0400, 0, "R12 t1");
        sc(0, 16'h0300, 0, "R12 t0");
        // R7: success clears the count; then R5/R6/R11 on thread 1.
        ll(1, 16'h0500, "R7"); sc(1, 16'h0500, 0, "R7 reset count");
        ll(1, 16'h0500, "R5");
        w0 = warn_seen;
        repeat (3) sc(1, 16'h0600, 0, "R6 fail");
        sc(1, 16'h0500, 1, "R5 uncached");
        sc(1, 16'h0500, 0, "R5 flag untouched");
        check("R5", "warns before fifth failure", warn_seen - w0, 0);
        repeat (30) sc(1, 16'h0600, 0, "R11 fail run");
        check("R11", "warns over saturated run", warn_seen - w0, 3);

        // Random traffic over three granules.
        for (int i = 0; i < 1500; i++) begin
            logic [AW-1:0] base [3];
            base[0] = 16'h0100; base[1] = 16'h0200; base[2] = 16'h0300;
            ll_valid    = ($urandom_range(0, 9) < 3);
            ll_tid      = TW'($urandom_range(0, NT - 1));
            ll_addr     = base[$urandom_range(0, 2)] | AW'($urandom_range(0, 15));
            sc_valid    = ($urandom_range(0, 9) < 5);
            sc_tid      = TW'($urandom_range(0, NT - 1));
            sc_addr     = base[$urandom_range(0, 2)] | AW'($urandom_range(0, 15));
            sc_uncached = ($urandom_range(0, 9) < 1);
            snp_valid   = ($urandom_range(0, 9) < 2);
            snp_addr    = base[$urandom_range(0, 2)] | AW'($urandom_range(0, 15));
            run_cycle("R2 R3 R4 R8 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule